// File: doc/BRIEF.md
# Transaction Read/Write Set Conflict Tracker

This block follows the memory footprint of one running hardware transaction. Each load or store that the core performs while a transaction is open is logged against its 64-byte cache line in a small fully associative table. Every entry holds a valid flag, a line tag and two marks: one for lines the transaction has read, and one for lines it has written. Coherence snoops from other agents carry an address and a read/write kind. Each snoop is compared against every valid entry in the same cycle. When it clashes with the footprint, the block raises a conflict abort pulse. The core then rolls back every change made by the transaction.

The two marks follow different rules. A line that was only read is disturbed only by a remote write. A line that was written is disturbed by any remote access. When a load or store needs a new line and every slot is occupied, the block raises an overflow abort pulse instead. The core logs this as a capacity failure, separate from a conflict. On commit or abort, the core asserts a clear input, which empties the whole table in a single cycle.

Top module: `rwset_tracker`

## Requirements
- R1: Lines are compared on address bits [ADDR_W-1:6] only; address bits 5:0 of local accesses and snoops have no effect on matching.
- R2: A load during an active transaction puts its line in the read set. A remote write (snp_is_write=1) to that line raises conflict_abort. A remote read (snp_is_write=0) to a read-only line does not.
- R3: A store during an active transaction puts its line in the write set. A remote read or a remote write to that line raises conflict_abort.
- R4: A store to a line already held for reading sets the write mark in the same entry and does not consume a new entry. The line then aborts on a remote read.
- R5: With all ENTRIES (default 16) slots in use, a local access to a new line raises overflow_abort and does not raise conflict_abort.
- R6: Loads and stores presented while txn_active is 0 are not recorded.
- R7: conflict_abort rises in the cycle after the clashing snoop is sampled and lasts exactly one cycle.
- R8: Asserting clear for one cycle invalidates every entry; earlier lines no longer clash, and all ENTRIES slots are free again.
- R9: After the first conflict_abort or overflow_abort pulse, further pulses are suppressed until clear is asserted.
- R10: After reset, both abort outputs are 0 and the table is empty.
- R11: If a conflict and an overflow arise in the same cycle, only conflict_abort is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_active | input | 1 | A transaction is open |
| clear | input | 1 | Commit or abort: empty the table |
| lcl_valid | input | 1 | A local load or store is presented |
| lcl_is_store | input | 1 | 1 = store, 0 = load |
| lcl_addr | input | ADDR_W | Byte address of the local access |
| snp_valid | input | 1 | A remote snoop is presented |
| snp_is_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_addr | input | ADDR_W | Byte address of the snoop |
| conflict_abort | output | 1 | One-cycle pulse: snoop clashed with the sets |
| overflow_abort | output | 1 | One-cycle pulse: no free entry for a new line |

## Verification
Snoops of both kinds are sent against lines that are read-only, written, and read-then-written. This separates the read-set rule from the write-set rule and shows that an upgrade keeps the same entry. Address pairs that differ only in the low six bits are compared with pairs that differ in bit 6, which checks the line granularity. The table is filled to exactly sixteen lines and then given a seventeenth line. This shows where overflow starts, and a combined overflow-plus-conflict cycle checks which abort wins. Accesses made outside a transaction, repeated clashes after an abort, and refills after clear each confirm that the tracker's state was or was not touched.

// File: rtl/rwset_pkg.sv
package rwset_pkg;
  typedef enum logic {
    SNOOP_RD = 1'b0,
    SNOOP_WR = 1'b1
  } snoop_kind_e;

  typedef struct packed {
    logic conflict;
    logic overflow;
  } abort_pulse_t;
endpackage

// File: rtl/rwset_pick.sv
module rwset_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (free_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/rwset_line.sv
module rwset_line
  import rwset_pkg::*;
#(
  parameter int TAG_W = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             touch_i,
  input  logic             alloc_i,
  input  logic             store_i,
  input  logic [TAG_W-1:0] lcl_tag_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  snoop_kind_e      snp_kind_i,
  output logic             valid_o,
  output logic             hit_o,
  output logic             clash_o
);
  logic             v_q, v_d;
  logic             rd_q, rd_d;
  logic             wr_q, wr_d;
  logic [TAG_W-1:0] tag_q;

  assign valid_o = v_q;
  assign hit_o   = v_q && (tag_q == lcl_tag_i);
  // written lines clash with anything; read-only lines only with remote writes
  assign clash_o = v_q && (tag_q == snp_tag_i) &&
                   (wr_q || (rd_q && snp_kind_i == SNOOP_WR));

  always_comb begin
    v_d  = v_q;
    rd_d = rd_q;
    wr_d = wr_q;
    if (clr_i) begin
      v_d  = 1'b0;
      rd_d = 1'b0;
      wr_d = 1'b0;
    end else if (alloc_i) begin
      v_d  = 1'b1;
      rd_d = !store_i;
      wr_d = store_i;
    end else if (touch_i && hit_o) begin
      rd_d = rd_q | !store_i;
      wr_d = wr_q | store_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      v_q  <= v_d;
      rd_q <= rd_d;
      wr_q <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (alloc_i && !clr_i) begin
      tag_q <= lcl_tag_i;
    end
  end

  p_mark_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q || rd_q) |-> v_q);
  p_alloc_into_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !v_q);
endmodule

// File: rtl/rwset_tracker.sv
module rwset_tracker
  import rwset_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int ENTRIES    = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_active,
  input  logic              clear,
  input  logic              lcl_valid,
  input  logic              lcl_is_store,
  input  logic [ADDR_W-1:0] lcl_addr,
  input  logic              snp_valid,
  input  logic              snp_is_write,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              conflict_abort,
  output logic              overflow_abort
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic [TAG_W-1:0]   lcl_tag, snp_tag;
  logic [ENTRIES-1:0] valid_vec, hit_vec, clash_vec, grant, alloc_vec;
  logic               any_free, any_hit, accept, need_new;
  logic               aborted_q, aborted_d;
  abort_pulse_t       pulse_q, pulse_d;
  snoop_kind_e        snp_kind;

  assign lcl_tag  = lcl_addr[ADDR_W-1:OFS_W];
  assign snp_tag  = snp_addr[ADDR_W-1:OFS_W];
  assign snp_kind = snoop_kind_e'(snp_is_write);

  rwset_pick #(.N(ENTRIES)) u_pick (
    .free_i  (~valid_vec),
    .grant_o (grant),
    .any_o   (any_free)
  );

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_line
      rwset_line #(.TAG_W(TAG_W)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clear),
        .touch_i    (accept),
        .alloc_i    (alloc_vec[gi]),
        .store_i    (lcl_is_store),
        .lcl_tag_i  (lcl_tag),
        .snp_tag_i  (snp_tag),
        .snp_kind_i (snp_kind),
        .valid_o    (valid_vec[gi]),
        .hit_o      (hit_vec[gi]),
        .clash_o    (clash_vec[gi])
      );
    end
  endgenerate

  always_comb begin
    accept    = lcl_valid && txn_active && !clear && !aborted_q;
    any_hit   = |hit_vec;
    need_new  = accept && !any_hit;
    alloc_vec = need_new ? grant : '0;
    pulse_d.conflict = snp_valid && (|clash_vec) && !aborted_q && !clear;
    pulse_d.overflow = need_new && !any_free && !pulse_d.conflict;
    if (clear) aborted_d = 1'b0;
    else       aborted_d = aborted_q || pulse_d.conflict || pulse_d.overflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q   <= '0;
      aborted_q <= 1'b0;
    end else begin
      pulse_q   <= pulse_d;
      aborted_q <= aborted_d;
    end
  end

  assign conflict_abort = pulse_q.conflict;
  assign overflow_abort = pulse_q.overflow;

  p_one_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(conflict_abort && overflow_abort));
  p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_abort || overflow_abort) |=> !(conflict_abort || overflow_abort));
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (valid_vec == '0));
  p_unique_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_idle_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_active && valid_vec == '0) |=> (valid_vec == '0));
  p_snoop_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_abort |-> $past(snp_valid));
endmodule

// File: tb/rwset_tracker_test.sv
module rwset_tracker_test;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          txn_active, clear, lcl_valid, lcl_is_store, snp_valid, snp_is_write;
  logic [AW-1:0] lcl_addr, snp_addr;
  logic          conflict_abort, overflow_abort;
  logic          got_c, got_o;
  int            total = 0;
  int            bad = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  rwset_tracker #(.ADDR_W(AW), .ENTRIES(16), .LINE_BYTES(64)) uut (
    .clk(clk), .rst_n(rst_n), .txn_active(txn_active), .clear(clear),
    .lcl_valid(lcl_valid), .lcl_is_store(lcl_is_store), .lcl_addr(lcl_addr),
    .snp_valid(snp_valid), .snp_is_write(snp_is_write), .snp_addr(snp_addr),
    .conflict_abort(conflict_abort), .overflow_abort(overflow_abort)
  );

  function automatic logic [AW-1:0] line(input int n);
    return 40'h0010_0000 + AW'(n) * 40'd64;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic step(input logic lv, input logic st, input logic [AW-1:0] la,
                      input logic sv, input logic sw, input logic [AW-1:0] sa,
                      input logic clr);
    @(negedge clk);
    lcl_valid = lv; lcl_is_store = st; lcl_addr = la;
    snp_valid = sv; snp_is_write = sw; snp_addr = sa; clear = clr;
    @(posedge clk);
    #1;
    got_c = conflict_abort;
    got_o = overflow_abort;
  endtask

  task automatic idle();        step(0, 0, '0, 0, 0, '0, 0); endtask
  task automatic do_clear();    step(0, 0, '0, 0, 0, '0, 1); endtask
  task automatic load(input logic [AW-1:0] a);  step(1, 0, a, 0, 0, '0, 0); endtask
  task automatic store(input logic [AW-1:0] a); step(1, 1, a, 0, 0, '0, 0); endtask
  task automatic snoop(input logic w, input logic [AW-1:0] a); step(0, 0, '0, 1, w, a, 0); endtask

  task automatic t_reset();
    chk("R10 conflict after reset", conflict_abort, 1'b0);
    chk("R10 overflow after reset", overflow_abort, 1'b0);
    txn_active = 1'b1;
    snoop(1, line(0));
    chk("R10 empty table no clash", got_c, 1'b0);
  endtask

  task automatic t_read_set();
    load(line(1));
    snoop(0, line(1));
    chk("R2 remote read on read line", got_c, 1'b0);
    snoop(1, line(1) | 40'h25);
    chk("R2 remote write on read line", got_c, 1'b1);
    chk("R11 no overflow with conflict", got_o, 1'b0);
    idle();
    chk("R7 pulse lasts one cycle", got_c, 1'b0);
    do_clear();
  endtask

  task automatic t_write_set();
    store(line(2));
    snoop(0, line(2));
    chk("R3 remote read on written line", got_c, 1'b1);
    do_clear();
    store(line(2));
    snoop(1, line(2));
    chk("R3 remote write on written line", got_c, 1'b1);
    do_clear();
  endtask

  task automatic t_latency();
    store(line(3));
    @(negedge clk);
    snp_valid = 1'b1; snp_is_write = 1'b0; snp_addr = line(3);
    #1;
    chk("R7 no combinational conflict", conflict_abort, 1'b0);
    @(posedge clk); #1;
    chk("R7 conflict one cycle later", conflict_abort, 1'b1);
    idle();
    chk("R7 conflict gone", got_c, 1'b0);
    do_clear();
  endtask

  task automatic t_granularity();
    load(line(4) + 40'h3F);
    snoop(1, line(4));
    chk("R1 low bits ignored", got_c, 1'b1);
    do_clear();
    load(line(4));
    snoop(1, line(5));
    chk("R1 next line distinct", got_c, 1'b0);
    do_clear();
  endtask

  task automatic t_upgrade();
    for (int i = 0; i < 16; i++) begin
      load(line(10 + i));
      chk("R4 fill with loads", got_o, 1'b0);
    end
    store(line(15));
    chk("R4 upgrade takes no entry", got_o, 1'b0);
    snoop(0, line(15));
    chk("R4 upgraded line aborts on read", got_c, 1'b1);
    do_clear();
  endtask

  task automatic t_capacity();
    for (int i = 0; i < 16; i++) begin
      store(line(40 + i));
      chk("R5 sixteen lines fit", got_o, 1'b0);
    end
    store(line(40));
    chk("R5 reuse of held line", got_o, 1'b0);
    store(line(60));
    chk("R5 seventeenth line overflows", got_o, 1'b1);
    chk("R5 overflow is not conflict", got_c, 1'b0);
    idle();
    chk("R5 overflow single cycle", got_o, 1'b0);
    do_clear();
  endtask

  task automatic t_suppress();
    load(line(70));
    snoop(1, line(70));
    chk("R9 first conflict", got_c, 1'b1);
    snoop(1, line(70));
    chk("R9 second conflict suppressed", got_c, 1'b0);
    do_clear();
    load(line(70));
    snoop(1, line(70));
    chk("R9 rearmed after clear", got_c, 1'b1);
    do_clear();
  endtask

  task automatic t_clear();
    store(line(80));
    do_clear();
    snoop(1, line(80));
    chk("R8 cleared line no clash", got_c, 1'b0);
    for (int i = 0; i < 16; i++) begin
      store(line(90 + i));
      chk("R8 all slots free after clear", got_o, 1'b0);
    end
    do_clear();
  endtask

  task automatic t_inactive();
    txn_active = 1'b0;
    store(line(120));
    txn_active = 1'b1;
    snoop(0, line(120));
    chk("R6 store outside txn ignored", got_c, 1'b0);
    do_clear();
  endtask

  task automatic t_priority();
    for (int i = 0; i < 16; i++) load(line(130 + i));
    step(1, 1, line(160), 1, 1, line(130), 0);
    chk("R11 conflict wins", got_c, 1'b1);
    chk("R11 overflow dropped", got_o, 1'b0);
    do_clear();
  endtask

  initial begin
    rst_n = 1'b0; txn_active = 1'b0; clear = 1'b0;
    lcl_valid = 1'b0; lcl_is_store = 1'b0; lcl_addr = '0;
    snp_valid = 1'b0; snp_is_write = 1'b0; snp_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    t_reset();
    t_read_set();
    t_write_set();
    t_latency();
    t_granularity();
    t_upgrade();
    t_capacity();
    t_suppress();
    t_clear();
    t_inactive();
    t_priority();
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule